// File: doc/BRIEF.md
# Indirect Scratch Register Window

This block puts a small bank of 8-bit configuration registers behind one 16-bit management word. A host selects the word by its address and reaches any byte in the bank through a pointer field in that word. A write with the update flag set stores a byte. A write with the flag clear only moves the pointer, and a later read of the word returns the byte that the pointer names. The bank holds GPIO output values, GPIO directions, three-bit function codes packed two pins per byte, and three configuration bytes. The configuration bytes decide whether the management interface is routed out over the GPIO pins.

Every GPIO pin has an output value, an output enable and a two-flop input synchronizer. The function code of a pin chooses between the pin's stored data bit and one of seven alternate sources. The alternate sources come in on a plain input vector, and the block does not interpret them. The host sequencer has three named states. ST_IDLE accepts an access. ST_COMMIT writes the staged byte into the bank, and ST_FETCH captures the addressed byte into the read word. The transitions are IDLE->COMMIT on a flagged write, IDLE->FETCH on a read, and COMMIT->IDLE and FETCH->IDLE unconditionally.

Top module: `scratch_window`

## Requirements
- R1: A host write to the window address with bit 15 set loads the pointer from bits 14:8 and stores bits 7:0 into the register that pointer names. The new value is visible on the outputs after the clock edge that follows the accepting edge.
- R2: A host write with bit 15 clear loads the pointer only. No bank register changes.
- R3: A host read of the window address is answered on host_rdata after the next clock edge, as {0, pointer, byte}. host_rdata holds that value until the next accepted read, and is 0 after reset.
- R4: GPIO pin n takes its stored data bit from pointer 0x00 + n/8, and its direction bit from pointer 0x08 + n/8, at bit n mod 8.
- R5: A direction bit of 1 makes the pin an input, with gpio_oe low. A direction bit of 0 drives gpio_oe high.
- R6: The function code of pin n sits at pointer 0x10 + n/2, in bits 2:0 for even n and bits 6:4 for odd n. Bits 3 and 7 store nothing and read 0. Code 0 drives the pin from its data bit. Code k (1 to 7) drives it from alt_in[n*8+k].
- R7: Reading a data register returns, for input pins, the pin level after a two-flop synchronizer, and for output pins, the stored value.
- R8: Pointer 0x40 holds a mode field in bits 1:0. gpio_busy is high exactly when that field is 1 or 2.
- R9: Pointer 0x42 bit 0 is the routing bit, and pointer 0x41 bit 0 is the no-CPU bit. smi_ext_sel equals the routing bit when no-CPU is 1 and its inverse when no-CPU is 0. smi_ext_sel is forced low while gpio_busy is high.
- R10: Pointers with no register behind them read as 0x00, and writes to them change nothing.
- R11: Reset clears every register. All pins then drive 0 with gpio_oe high, gpio_busy is 0, and smi_ext_sel is 1.
- R12: A strobe in the cycle after an accepted access is dropped. A write and a read in the same cycle count as a write. Strobes to any other host address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | ADDR_W | Host register address; the window answers at WIN_ADDR |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 16 | Write word: flag, pointer, byte |
| host_rdata | output | 16 | Read word: 0, pointer, byte |
| gpio_in | input | NUM_PINS | Pad input levels |
| gpio_out | output | NUM_PINS | Pad output values |
| gpio_oe | output | NUM_PINS | Pad output enables, high drives |
| alt_in | input | NUM_PINS*8 | Alternate function sources, eight slots per pin |
| gpio_busy | output | 1 | GPIO pins claimed by port mode |
| smi_ext_sel | output | 1 | Management interface routed to the pins |

## Verification
The bench goes after the pointer-only write. A design that committed regardless of the flag would overwrite a byte on a read setup. It also checks the packing of odd pins into bits 6:4, where a wrong shift sends the code to the neighbouring pin. The inverted routing meaning when the no-CPU bit is clear gets its own test, because a design without the inversion reports the opposite route. Strobes arriving back to back with an accepted access are tested too: a design that took them would commit the second byte. Each synchronized read is taken at least three cycles after the input moves, so a missing or extra synchronizer stage shows as a mismatch against the cycle model.

// File: rtl/scratch_window_pkg.sv
package scratch_window_pkg;

    localparam int PTR_W  = 7;
    localparam int BYTE_W = 8;
    localparam int FUNC_W = 3;
    localparam int ALT_W  = 8;

    localparam logic [PTR_W-1:0] PTR_DATA  = 7'h00;
    localparam logic [PTR_W-1:0] PTR_DIR   = 7'h08;
    localparam logic [PTR_W-1:0] PTR_FUNC  = 7'h10;
    localparam logic [PTR_W-1:0] PTR_MODE  = 7'h40;
    localparam logic [PTR_W-1:0] PTR_CPU   = 7'h41;
    localparam logic [PTR_W-1:0] PTR_ROUTE = 7'h42;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_FETCH  = 2'd2
    } win_state_e;

endpackage

// File: rtl/scratch_host_fsm.sv
module scratch_host_fsm
    import scratch_window_pkg::*;
#(
    parameter int                ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] WIN_ADDR = 5'h0C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [15:0]         host_wdata,
    input  logic [BYTE_W-1:0]   rbyte,
    output logic                bank_we,
    output logic [PTR_W-1:0]    bank_ptr,
    output logic [BYTE_W-1:0]   bank_wbyte,
    output logic [15:0]         host_rdata,
    output win_state_e          state
);

    win_state_e          state_q, state_d;
    logic                hit, take_wr, take_commit, take_rd;
    logic [PTR_W-1:0]    ptr_q;
    logic [BYTE_W-1:0]   stage_q;
    logic [15:0]         rdata_q;

    assign hit         = (host_addr == WIN_ADDR);
    assign take_wr     = (state_q == ST_IDLE) && hit && host_wr;
    assign take_commit = take_wr && host_wdata[15];
    assign take_rd     = (state_q == ST_IDLE) && hit && host_rd && !host_wr;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_commit)  state_d = ST_COMMIT;
                else if (take_rd) state_d = ST_FETCH;
            end
            ST_COMMIT: state_d = ST_IDLE;
            ST_FETCH:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            stage_q <= '0;
            rdata_q <= '0;
        end else begin
            if (take_wr) begin
                ptr_q   <= host_wdata[14:8];
                stage_q <= host_wdata[7:0];
            end
            if (state_q == ST_FETCH) rdata_q <= {1'b0, ptr_q, rbyte};
        end
    end

    // outputs
    always_comb begin
        bank_we    = (state_q == ST_COMMIT);
        bank_ptr   = ptr_q;
        bank_wbyte = stage_q;
        host_rdata = rdata_q;
        state      = state_q;
    end

endmodule

// File: rtl/scratch_bank.sv
module scratch_bank
    import scratch_window_pkg::*;
#(
    parameter int NUM_PINS   = 16,
    localparam int DATA_BYTES = (NUM_PINS + 7) / 8,
    localparam int FUNC_BYTES = (NUM_PINS + 1) / 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [PTR_W-1:0]           ptr,
    input  logic [BYTE_W-1:0]          wbyte,
    input  logic [NUM_PINS-1:0]        pin_level,
    output logic [BYTE_W-1:0]          rbyte,
    output logic [NUM_PINS-1:0]        data_bits,
    output logic [NUM_PINS-1:0]        dir_bits,
    output logic [NUM_PINS*FUNC_W-1:0] func_codes,
    output logic [1:0]                 port_mode,
    output logic                       no_cpu,
    output logic                       route_bit
);

    logic [DATA_BYTES*8-1:0] data_q, dir_q, level_pad, data_view;
    logic [FUNC_BYTES*8-1:0] func_q;
    logic [BYTE_W-1:0]       mode_q, cpu_q, route_q;

    function automatic logic [7:0] pin_mask(input int b);
        logic [7:0] m;
        for (int i = 0; i < 8; i++) m[i] = ((b * 8 + i) < NUM_PINS);
        return m;
    endfunction

    function automatic logic [7:0] func_mask(input int f);
        logic [7:0] m;
        m = 8'h07;
        if ((2 * f + 1) < NUM_PINS) m = m | 8'h70;
        return m;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            dir_q   <= '0;
            func_q  <= '0;
            mode_q  <= '0;
            cpu_q   <= '0;
            route_q <= '0;
        end else if (we) begin
            for (int b = 0; b < DATA_BYTES; b++) begin
                if (ptr == PTR_W'(PTR_DATA + b)) data_q[b*8 +: 8] <= wbyte & pin_mask(b);
                if (ptr == PTR_W'(PTR_DIR + b))  dir_q[b*8 +: 8]  <= wbyte & pin_mask(b);
            end
            for (int f = 0; f < FUNC_BYTES; f++) begin
                if (ptr == PTR_W'(PTR_FUNC + f)) func_q[f*8 +: 8] <= wbyte & func_mask(f);
            end
            if (ptr == PTR_MODE)  mode_q  <= wbyte;
            if (ptr == PTR_CPU)   cpu_q   <= wbyte;
            if (ptr == PTR_ROUTE) route_q <= wbyte;
        end
    end

    // pin view of the data registers: inputs show the synchronized level
    always_comb begin
        level_pad = '0;
        level_pad[NUM_PINS-1:0] = pin_level;
        data_view = (dir_q & level_pad) | (~dir_q & data_q);
    end

    always_comb begin
        rbyte = '0;
        for (int b = 0; b < DATA_BYTES; b++) begin
            if (ptr == PTR_W'(PTR_DATA + b)) rbyte = data_view[b*8 +: 8];
            if (ptr == PTR_W'(PTR_DIR + b))  rbyte = dir_q[b*8 +: 8];
        end
        for (int f = 0; f < FUNC_BYTES; f++) begin
            if (ptr == PTR_W'(PTR_FUNC + f)) rbyte = func_q[f*8 +: 8];
        end
        if (ptr == PTR_MODE)  rbyte = mode_q;
        if (ptr == PTR_CPU)   rbyte = cpu_q;
        if (ptr == PTR_ROUTE) rbyte = route_q;
    end

    assign data_bits = data_q[NUM_PINS-1:0];
    assign dir_bits  = dir_q[NUM_PINS-1:0];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_func
        assign func_codes[p*FUNC_W +: FUNC_W] = func_q[(p/2)*8 + (p%2)*4 +: FUNC_W];
    end

    assign port_mode = mode_q[1:0];
    assign no_cpu    = cpu_q[0];
    assign route_bit = route_q[0];

endmodule

// File: rtl/scratch_gpio_pin.sv
module scratch_gpio_pin
    import scratch_window_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_in,
    input  logic              data_bit,
    input  logic [FUNC_W-1:0] func,
    input  logic [ALT_W-1:0]  alt,
    input  logic              pad_i,
    output logic              pad_o,
    output logic              pad_oe,
    output logic              level
);

    logic sync1_q, sync2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= pad_i;
            sync2_q <= sync1_q;
        end
    end

    assign level  = sync2_q;
    assign pad_oe = ~dir_in;
    assign pad_o  = (func == '0) ? data_bit : alt[func];

endmodule

// File: rtl/scratch_smi_route.sv
module scratch_smi_route (
    input  logic [1:0] port_mode,
    input  logic       no_cpu,
    input  logic       route_bit,
    output logic       gpio_busy,
    output logic       smi_ext_sel
);

    logic want_ext;

    always_comb begin
        gpio_busy   = (port_mode == 2'd1) || (port_mode == 2'd2);
        want_ext    = no_cpu ? route_bit : ~route_bit;
        smi_ext_sel = want_ext && !gpio_busy;
    end

endmodule

// File: rtl/scratch_window.sv
module scratch_window
    import scratch_window_pkg::*;
#(
    parameter int                NUM_PINS = 16,
    parameter int                ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] WIN_ADDR = 5'h0C
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         host_addr,
    input  logic                      host_wr,
    input  logic                      host_rd,
    input  logic [15:0]               host_wdata,
    output logic [15:0]               host_rdata,
    input  logic [NUM_PINS-1:0]       gpio_in,
    output logic [NUM_PINS-1:0]       gpio_out,
    output logic [NUM_PINS-1:0]       gpio_oe,
    input  logic [NUM_PINS*ALT_W-1:0] alt_in,
    output logic                      gpio_busy,
    output logic                      smi_ext_sel
);

    win_state_e                 fsm_state;
    logic                       bank_we;
    logic [PTR_W-1:0]           bank_ptr;
    logic [BYTE_W-1:0]          bank_wbyte, bank_rbyte;
    logic [NUM_PINS-1:0]        data_bits, dir_bits, pin_level;
    logic [NUM_PINS*FUNC_W-1:0] func_codes;
    logic [1:0]                 port_mode;
    logic                       no_cpu, route_bit;

    scratch_host_fsm #(.ADDR_W(ADDR_W), .WIN_ADDR(WIN_ADDR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .rbyte      (bank_rbyte),
        .bank_we    (bank_we),
        .bank_ptr   (bank_ptr),
        .bank_wbyte (bank_wbyte),
        .host_rdata (host_rdata),
        .state      (fsm_state)
    );

    scratch_bank #(.NUM_PINS(NUM_PINS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (bank_we),
        .ptr        (bank_ptr),
        .wbyte      (bank_wbyte),
        .pin_level  (pin_level),
        .rbyte      (bank_rbyte),
        .data_bits  (data_bits),
        .dir_bits   (dir_bits),
        .func_codes (func_codes),
        .port_mode  (port_mode),
        .no_cpu     (no_cpu),
        .route_bit  (route_bit)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        scratch_gpio_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .dir_in   (dir_bits[p]),
            .data_bit (data_bits[p]),
            .func     (func_codes[p*FUNC_W +: FUNC_W]),
            .alt      (alt_in[p*ALT_W +: ALT_W]),
            .pad_i    (gpio_in[p]),
            .pad_o    (gpio_out[p]),
            .pad_oe   (gpio_oe[p]),
            .level    (pin_level[p])
        );
    end

    scratch_smi_route u_route (
        .port_mode   (port_mode),
        .no_cpu      (no_cpu),
        .route_bit   (route_bit),
        .gpio_busy   (gpio_busy),
        .smi_ext_sel (smi_ext_sel)
    );

endmodule

// File: rtl/scratch_window_chk.sv
module scratch_window_chk
    import scratch_window_pkg::*;
#(
    parameter int                NUM_PINS = 16,
    parameter int                ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] WIN_ADDR = 5'h0C
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   host_addr,
    input logic                host_wr,
    input logic                host_rd,
    input logic [15:0]         host_wdata,
    input logic [15:0]         host_rdata,
    input logic [NUM_PINS-1:0] gpio_oe,
    input logic                gpio_busy,
    input logic                smi_ext_sel,
    input win_state_e          state,
    input logic                bank_we,
    input logic [PTR_W-1:0]    bank_ptr,
    input logic [BYTE_W-1:0]   bank_wbyte
);

    p_flag_commits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && host_addr == WIN_ADDR && host_wr && host_wdata[15])
        |=> (bank_we && bank_ptr == $past(host_wdata[14:8]) && bank_wbyte == $past(host_wdata[7:0])));

    p_no_flag_no_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && host_addr == WIN_ADDR && host_wr && !host_wdata[15]) |=> !bank_we);

    p_rdata_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FETCH) |=> $stable(host_rdata));

    p_rdata_top_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rdata[15]);

    if (NUM_PINS >= 8) begin : g_dir_chk
        p_dir_sets_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_we && bank_ptr == PTR_DIR) |=> (gpio_oe[7:0] == ~$past(bank_wbyte)));
    end

    p_busy_blocks_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_busy |-> !smi_ext_sel);

    p_busy_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state == ST_IDLE));

    p_no_take_when_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> !bank_we);

endmodule

bind scratch_window scratch_window_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .WIN_ADDR (WIN_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .gpio_oe     (gpio_oe),
    .gpio_busy   (gpio_busy),
    .smi_ext_sel (smi_ext_sel),
    .state       (fsm_state),
    .bank_we     (bank_we),
    .bank_ptr    (bank_ptr),
    .bank_wbyte  (bank_wbyte)
);

// File: tb/sim_scratch_window.sv
`timescale 1ns/1ps
module sim_scratch_window;

    localparam int NP  = 16;
    localparam int WIN = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      host_addr = 5'd12;
    logic            host_wr = 1'b0;
    logic            host_rd = 1'b0;
    logic [15:0]     host_wdata = '0;
    logic [15:0]     host_rdata;
    logic [NP-1:0]   gpio_in = '0;
    logic [NP-1:0]   gpio_out, gpio_oe;
    logic [NP*8-1:0] alt_in = '0;
    logic            gpio_busy, smi_ext_sel;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    scratch_window u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .alt_in(alt_in), .gpio_busy(gpio_busy), .smi_ext_sel(smi_ext_sel)
    );

    // ---------------- behavioural reference model ----------------
    int m_regs[128];
    int m_st, m_ptr, m_stage, m_rdata;
    bit m_s1[NP], m_s2[NP];
    bit m_live = 0;

    function automatic int impl_mask(int p);
        if (p < 2) return 255;
        if (p >= 8 && p < 10) return 255;
        if (p >= 16 && p < 24) return 8'h77;
        if (p >= 64 && p < 67) return 255;
        return 0;
    endfunction

    function automatic int rd_byte(int p);
        int v;
        if (impl_mask(p) == 0) return 0;
        if (p < 2) begin
            v = 0;
            for (int i = 0; i < 8; i++) begin
                int pin;
                pin = p * 8 + i;
                if (((m_regs[8 + p] >> i) & 1) == 1) v = v | (int'(m_s2[pin]) << i);
                else v = v | (((m_regs[p] >> i) & 1) << i);
            end
            return v;
        end
        return m_regs[p];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) m_regs[i] = 0;
            for (int i = 0; i < NP; i++) begin m_s1[i] = 0; m_s2[i] = 0; end
            m_st = 0; m_ptr = 0; m_stage = 0; m_rdata = 0;
            m_live = 1;
        end else begin
            int rb;
            rb = rd_byte(m_ptr);
            if (m_st == 1) begin
                m_regs[m_ptr] = m_stage & impl_mask(m_ptr);
                m_st = 0;
            end else if (m_st == 2) begin
                m_rdata = (m_ptr << 8) | rb;
                m_st = 0;
            end else if (int'(host_addr) == WIN && host_wr) begin
                m_ptr = (int'(host_wdata) >> 8) & 127;
                if (host_wdata[15]) begin
                    m_stage = int'(host_wdata) & 255;
                    m_st = 1;
                end
            end else if (int'(host_addr) == WIN && host_rd) begin
                m_st = 2;
            end
            for (int i = 0; i < NP; i++) begin
                m_s2[i] = m_s1[i];
                m_s1[i] = gpio_in[i];
            end
        end
    end

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && m_live && !done) begin
            int e_oe, e_out, mode, e_busy, e_sel;
            e_oe = 0; e_out = 0;
            for (int p = 0; p < NP; p++) begin
                int f;
                f = (m_regs[16 + p / 2] >> ((p % 2) * 4)) & 7;
                if (((m_regs[8 + p / 8] >> (p % 8)) & 1) == 0) e_oe = e_oe | (1 << p);
                if (f == 0) e_out = e_out | (((m_regs[p / 8] >> (p % 8)) & 1) << p);
                else        e_out = e_out | (int'(alt_in[p * 8 + f]) << p);
            end
            mode   = m_regs[64] & 3;
            e_busy = (mode == 1 || mode == 2) ? 1 : 0;
            e_sel  = ((m_regs[65] & 1) == 1) ? (m_regs[66] & 1) : (1 - (m_regs[66] & 1));
            if (e_busy == 1) e_sel = 0;
            check("R3 model rdata", int'(host_rdata), m_rdata);
            check("R5 model oe", int'(gpio_oe), e_oe);
            check("R6 model out", int'(gpio_out), e_out);
            check("R8 model busy", int'(gpio_busy), e_busy);
            check("R9 model route", int'(smi_ext_sel), e_sel);
        end
    end

    // ---------------- stimulus ----------------
    task automatic host_write(logic [4:0] a, logic [15:0] w);
        @(negedge clk);
        host_addr = a; host_wr = 1'b1; host_wdata = w;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 5'd12;
        @(negedge clk);
    endtask

    task automatic host_read(string req, int exp);
        @(negedge clk);
        host_addr = 5'd12; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        @(negedge clk);
        check(req, int'(host_rdata), exp);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R11 reset oe", int'(gpio_oe), 16'hFFFF);
        check("R11 reset out", int'(gpio_out), 0);
        check("R11 reset rdata", int'(host_rdata), 0);
        check("R11 reset busy", int'(gpio_busy), 0);
        check("R11 reset route", int'(smi_ext_sel), 1);

        host_write(5'd12, 16'h88F0);
        check("R5 dir sets oe", int'(gpio_oe), 16'hFF0F);
        host_write(5'd12, 16'h80A5);
        check("R4 R1 data drives pins", int'(gpio_out), 16'h00A5);

        @(negedge clk); gpio_in = 16'h00C0;
        idle(3);
        host_write(5'd12, 16'h0000);
        host_read("R7 R3 mixed read", 16'h00C5);
        host_write(5'd12, 16'h0055);
        host_read("R2 pointer only", 16'h00C5);

        @(negedge clk); alt_in = '0; alt_in[2] = 1'b1; alt_in[11] = 1'b1;
        host_write(5'd12, 16'h9032);
        check("R6 even odd codes", int'(gpio_out), 16'h00A7);
        host_write(5'd12, 16'h90FF);
        host_read("R6 code mask", 16'h1077);
        check("R6 code seven", int'(gpio_out), 16'h00A4);

        host_write(5'd12, 16'hC001);
        check("R8 mode one busy", int'(gpio_busy), 1);
        check("R9 busy blocks", int'(smi_ext_sel), 0);
        host_write(5'd12, 16'hC002);
        check("R8 mode two busy", int'(gpio_busy), 1);
        host_write(5'd12, 16'hC003);
        check("R8 mode three free", int'(gpio_busy), 0);
        check("R9 inverted when cpu", int'(smi_ext_sel), 1);
        host_write(5'd12, 16'hC201);
        check("R9 inverted route set", int'(smi_ext_sel), 0);
        host_write(5'd12, 16'hC101);
        check("R9 direct route", int'(smi_ext_sel), 1);
        host_write(5'd12, 16'hC200);
        check("R9 direct route clear", int'(smi_ext_sel), 0);

        host_write(5'd12, 16'hFF5A);
        host_read("R10 empty pointer", 16'h7F00);

        // back-to-back: second write lands in the commit cycle
        @(negedge clk);
        host_addr = 5'd12; host_wr = 1'b1; host_wdata = 16'h8011;
        @(negedge clk);
        host_wdata = 16'h8022;
        @(negedge clk);
        host_wr = 1'b0;
        @(negedge clk);
        host_read("R12 dropped strobe", 16'h00C1);

        @(negedge clk);
        host_addr = 5'd12; host_wr = 1'b1; host_rd = 1'b1; host_wdata = 16'h8033;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        @(negedge clk);
        host_read("R12 write wins", 16'h00C3);

        @(negedge clk); gpio_in = 16'h0030;
        idle(3);
        host_read("R7 input follows", 16'h0033);

        host_write(5'd3, 16'h80FF);
        host_read("R12 other address", 16'h0033);

        idle(2);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL R12 watchdog: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule